// File: doc/BRIEF.md
# Alert Sender with Test Injection

This block turns event requests from a peripheral into alerts for an external receiver. Each of its channels runs its own request/acknowledge handshake. A channel raises its alert request, holds it until the receiver acknowledges, and then waits through a short quiet gap before it can raise the request again.

A channel can be triggered in two ways. The first is a hardware event input. The second is one bit of a write-only test port that software uses to inject alerts. A test write has no storage: it is a single-cycle strobe, and a channel acts on it only when that channel is idle. A hardware event that arrives while its channel is busy is not lost. It is kept in a pending bit and served as soon as the quiet gap ends.

Channels marked fatal by a parameter mask latch their first event. From then on they re-raise the alert one handshake after another until the block is reset.

Top module: `alert_notifier`

## Requirements
- R1: While `rst` is high at a rising clock edge, every channel returns to idle, and every pending bit and fatal latch is cleared. `alertOut` reads all zero from that edge on.
- R2: A test write (`testWrEn` high, with bit i of `testWrData` set) sampled at an edge where channel i is idle makes `alertOut[i]` high right after that edge. Bits written as 0 raise nothing.
- R3: A test write that reaches a channel while that channel is busy is ignored and leaves no trace. A channel is busy while its request is high and also during its quiet gap, including the gap's last cycle.
- R4: `alertOut[i]` stays high until `ackIn[i]` is sampled high at an edge. It falls right after that edge.
- R5: After an acknowledge, `alertOut[i]` stays low for at least two cycles. If a trigger is waiting, the request rises again after exactly two low cycles.
- R6: One test write produces exactly one handshake on each selected channel. The request does not re-fire by itself afterwards.
- R7: A hardware event sampled at an edge where its channel is idle raises `alertOut[i]` right after that edge.
- R8: A hardware event sampled while its channel is busy is remembered. It starts one more handshake as soon as the gap ends.
- R9: On a channel whose bit is set in `FATAL_MASK` (default: channel 3 only), one event starts back-to-back handshakes that continue after the event input returns low. Only reset stops them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hwEvent | input | NUM_CH | Hardware event request per channel |
| testWrEn | input | 1 | Strobe for a write to the test port |
| testWrData | input | NUM_CH | Test write data, one bit per channel |
| ackIn | input | NUM_CH | Acknowledge from the receiver per channel |
| alertOut | output | NUM_CH | Alert request per channel |

## Verification
The block is driven with several kinds of test write:
- A write that selects several channels at once, which shows that zero bits stay silent.
- Repeated writes during the request phase, the first gap cycle and the last gap cycle, which separate "ignored while busy" from "queued".
- A single write, which shows whether a request re-fires on its own.

Hardware event pulses are applied both to an idle channel and to a busy one, to tell direct service apart from pending-bit service. The receiver model acknowledges after a fixed delay, and on one channel that delay is stretched, so the rise time of every request can be predicted and the two-cycle gap can be measured. A pulse on the fatal channel shows the repeat persisting after the event input clears, and shows that reset ends it.

// File: rtl/alert_snd_pkg.sv
package alert_snd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALERT = 2'd1,
    ST_GAP   = 2'd2
  } chState_e;

  // control -> datapath strobes, one per channel
  typedef struct packed {
    logic launch;  // channel starts a handshake this cycle
    logic idle;    // channel may accept a test write
  } chStrobe_t;

endpackage

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import alert_snd_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int GAP_LEN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       hwTrig,
  input  logic [NUM_CH-1:0]       testGo,
  input  logic [NUM_CH-1:0]       ackIn,
  output logic [NUM_CH-1:0]       alertOut,
  output chStrobe_t [NUM_CH-1:0]  strb
);

  localparam int CW = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;
  localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_LEN - 1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chState_e      chSt;
    logic [CW-1:0] gapCnt;
    logic          gapEnd;
    logic          launch;

    assign gapEnd = (chSt == ST_GAP) && (gapCnt == '0);
    assign launch = ((chSt == ST_IDLE) && (hwTrig[i] || testGo[i])) ||
                    (gapEnd && hwTrig[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        chSt   <= ST_IDLE;
        gapCnt <= '0;
      end else begin
        unique case (chSt)
          ST_IDLE: begin
            if (launch) chSt <= ST_ALERT;
          end
          ST_ALERT: begin
            if (ackIn[i]) begin
              chSt   <= ST_GAP;
              gapCnt <= GAP_LOAD;
            end
          end
          ST_GAP: begin
            if (gapCnt == '0) chSt <= launch ? ST_ALERT : ST_IDLE;
            else              gapCnt <= gapCnt - 1'b1;
          end
          default: chSt <= ST_IDLE;
        endcase
      end
    end

    assign alertOut[i]    = (chSt == ST_ALERT);
    assign strb[i].launch = launch;
    assign strb[i].idle   = (chSt == ST_IDLE);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      alertOut[i] && !ackIn[i] |=> alertOut[i]);

    // R4
    drop_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(alertOut[i]) && !$past(rst) |-> $past(ackIn[i]));

    // R5
    min_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(alertOut[i]) && !$past(rst) |=> !alertOut[i]);
  end

endmodule

// File: rtl/alert_dp.sv
module alert_dp
  import alert_snd_pkg::*;
#(
  parameter int                NUM_CH     = 4,
  parameter logic [NUM_CH-1:0] FATAL_MASK = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      hwEvent,
  input  logic                   testWrEn,
  input  logic [NUM_CH-1:0]      testWrData,
  input  chStrobe_t [NUM_CH-1:0] strb,
  output logic [NUM_CH-1:0]      hwTrig,
  output logic [NUM_CH-1:0]      testGo
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic pendBit;
    logic fatalLat;

    // events seen while not launching are held for the next free slot
    always_ff @(posedge clk) begin
      if (rst) pendBit <= 1'b0;
      else     pendBit <= (pendBit || hwEvent[i]) && !strb[i].launch;
    end

    if (FATAL_MASK[i]) begin : g_fatal
      always_ff @(posedge clk) begin
        if (rst)             fatalLat <= 1'b0;
        else if (hwEvent[i]) fatalLat <= 1'b1;
      end

      // R9
      fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fatalLat) && !$past(rst) |-> fatalLat);
    end else begin : g_recov
      assign fatalLat = 1'b0;
    end

    assign hwTrig[i] = hwEvent[i] || pendBit || fatalLat;
    assign testGo[i] = testWrEn && testWrData[i] && strb[i].idle;
  end

endmodule

// File: rtl/alert_notifier.sv
module alert_notifier
  import alert_snd_pkg::*;
#(
  parameter int                NUM_CH     = 4,
  parameter int                GAP_LEN    = 2,
  parameter logic [NUM_CH-1:0] FATAL_MASK = NUM_CH'(1) << (NUM_CH - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hwEvent,
  input  logic              testWrEn,
  input  logic [NUM_CH-1:0] testWrData,
  input  logic [NUM_CH-1:0] ackIn,
  output logic [NUM_CH-1:0] alertOut
);

  chStrobe_t [NUM_CH-1:0] strb;
  logic [NUM_CH-1:0]      hwTrig;
  logic [NUM_CH-1:0]      testGo;

  alert_dp #(
    .NUM_CH    (NUM_CH),
    .FATAL_MASK(FATAL_MASK)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .hwEvent   (hwEvent),
    .testWrEn  (testWrEn),
    .testWrData(testWrData),
    .strb      (strb),
    .hwTrig    (hwTrig),
    .testGo    (testGo)
  );

  alert_ctrl #(
    .NUM_CH (NUM_CH),
    .GAP_LEN(GAP_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .hwTrig  (hwTrig),
    .testGo  (testGo),
    .ackIn   (ackIn),
    .alertOut(alertOut),
    .strb    (strb)
  );

endmodule

// File: tb/alert_notifier_test.sv
module alert_notifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int WD_LIMIT   = 3000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] hwEvent = '0;
  logic           testWrEn = 1'b0;
  logic [NCH-1:0] testWrData = '0;
  logic [NCH-1:0] autoAck = '1;
  logic [NCH-1:0] manAck = '0;
  logic [NCH-1:0] rspAck = '0;
  logic [NCH-1:0] ackIn;
  logic [NCH-1:0] alertOut;

  assign ackIn = rspAck | manAck;

  alert_notifier #(.NUM_CH(NCH), .GAP_LEN(2), .FATAL_MASK(4'b1000)) uut (
    .clk(clk), .rst(rst), .hwEvent(hwEvent), .testWrEn(testWrEn),
    .testWrData(testWrData), .ackIn(ackIn), .alertOut(alertOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  typedef struct {
    int    cyc;
    string tag;
  } expItem_t;
  expItem_t expQ[NCH][$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expectRise(input int ch, input int c, input string tag);
    expItem_t it;
    it.cyc = c;
    it.tag = tag;
    expQ[ch].push_back(it);
  endtask

  task automatic checkDrained(input string tag);
    for (int i = 0; i < NCH; i++) chk(expQ[i].size() == 0, tag, expQ[i].size(), 0);
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // receiver model: acknowledge on the second low-phase sample of a high request
  int hiCnt[NCH];
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rst || !alertOut[i]) begin
        hiCnt[i]  = 0;
        rspAck[i] = 1'b0;
      end else begin
        hiCnt[i]  = hiCnt[i] + 1;
        rspAck[i] = autoAck[i] && (hiCnt[i] == 2);
      end
    end
  end

  // monitor: every rising request is matched against the scoreboard
  logic [NCH-1:0] prevOut = '0;
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (alertOut[i] && !prevOut[i]) begin
        if (expQ[i].size() == 0) begin
          checkCnt++;
          failCnt++;
          $display("FAIL R6: unexpected rise on channel %0d at cycle %0d, actual 1 expected 0",
                   i, cyc);
        end else begin
          expItem_t it;
          it = expQ[i].pop_front();
          chk(it.cyc == cyc, it.tag, cyc, it.cyc);
        end
      end
    end
    prevOut = alertOut;
  end

  always @(posedge clk) begin
    if (cyc >= WD_LIMIT && !done) begin
      done = 1;
      failCnt++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic testWrite(input logic [NCH-1:0] bits);
    testWrEn   = 1'b1;
    testWrData = bits;
    @(negedge clk);
    testWrEn   = 1'b0;
    testWrData = '0;
  endtask

  initial begin
    int c;
    // R1: reset state
    waitNeg(2);
    chk(alertOut == '0, "R1 in reset", alertOut, 0);
    rst = 1'b0;
    waitNeg(1);
    chk(alertOut == '0, "R1 after reset", alertOut, 0);
    waitNeg(2);

    // R2, R6: multi-channel test write, zero bits silent, single handshake each
    c = cyc;
    expectRise(0, c + 1, "R2 ch0");
    expectRise(2, c + 1, "R2 ch2");
    testWrite(4'b0101);
    waitNeg(12);
    checkDrained("R6 single handshake");

    // R3: writes during request, first gap cycle, last gap cycle are ignored
    c = cyc;
    expectRise(1, c + 1, "R3 first write");
    testWrite(4'b0010);          // sampled at c+1, idle
    testWrite(4'b0010);          // sampled at c+2, request high
    waitNeg(1);
    testWrite(4'b0010);          // sampled at c+4, gap first cycle
    testWrite(4'b0010);          // sampled at c+5, gap last cycle
    waitNeg(12);
    checkDrained("R3 busy writes ignored");

    // R4: request held without acknowledge, drops right after acknowledge
    autoAck[0] = 1'b0;
    c = cyc;
    expectRise(0, c + 1, "R4 rise");
    testWrite(4'b0001);
    waitNeg(10);
    chk(alertOut[0] == 1'b1, "R4 held", alertOut[0], 1);
    manAck[0] = 1'b1;
    waitNeg(1);
    chk(alertOut[0] == 1'b0, "R4 drop after ack", alertOut[0], 0);
    manAck[0] = 1'b0;
    autoAck[0] = 1'b1;
    waitNeg(8);
    checkDrained("R4 drained");

    // R7, R8, R5: event on idle channel, then event while busy served after gap
    c = cyc;
    expectRise(2, c + 1, "R7 idle event");
    expectRise(2, c + 5, "R8 pending event after R5 gap");
    hwEvent[2] = 1'b1;
    waitNeg(1);
    hwEvent[2] = 1'b0;
    waitNeg(1);
    hwEvent[2] = 1'b1;           // sampled while request high
    waitNeg(1);
    hwEvent[2] = 1'b0;
    chk(alertOut[2] == 1'b0, "R5 gap cycle 1", alertOut[2], 0);
    waitNeg(1);
    chk(alertOut[2] == 1'b0, "R5 gap cycle 2", alertOut[2], 0);
    waitNeg(1);
    chk(alertOut[2] == 1'b1, "R5 re-rise", alertOut[2], 1);
    waitNeg(10);
    checkDrained("R8 drained");

    // R9: fatal channel repeats after the event clears, until reset
    c = cyc;
    for (int k = 0; k < 4; k++) expectRise(3, c + 1 + 4*k, "R9 repeat");
    hwEvent[3] = 1'b1;
    waitNeg(1);
    hwEvent[3] = 1'b0;
    waitNeg(15);                 // now at cycle c+16
    rst = 1'b1;
    waitNeg(2);
    chk(alertOut == '0, "R1 reset stops fatal", alertOut, 0);
    rst = 1'b0;
    waitNeg(16);
    chk(alertOut == '0, "R9 silent after reset", alertOut, 0);
    checkDrained("R9 drained");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule